// File: doc/BRIEF.md
# Page write buffer controller

This block gathers the data bytes of one serial write session into a page-sized staging buffer and then programs them into a byte array. A session opens with a load-address strobe. That strobe sets a page number and a starting offset. Each accepted data byte lands at the current offset, and the offset then advances. The offset wraps inside the page, so loading more bytes than the page holds overwrites the earliest bytes. A STOP strobe ends the session. If the session holds data and was not refused, the STOP starts a write cycle that copies every loaded slot to the array write port and holds busy for a programmable number of clock cycles.

Write protection is decided once per session. A sample strobe, issued before the first data byte, latches the write-protect pin. If the latched level is high, the first byte and every later byte of that session are refused with a NACK, and the STOP that follows programs nothing. The array itself sits outside the block and is reached only through the write port. Unloaded slots are never written, so untouched locations keep their erased value.

Data bytes enter through a valid/ready handshake. A byte counts as transferred only in a cycle where `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is low for the whole write cycle and in any cycle that also carries a STOP or a load-address strobe. An upstream source must hold the byte until the handshake completes. The decision for each transferred byte appears exactly one cycle later on `ack_valid_o`/`ack_o`.

Top module: `pgwr_ctrl`

## Requirements
- R1: A load-address strobe opens a session and takes the 14-bit address. Bits 13:6 form the page number and bits 5:0 form the offset, and `cur_addr_o` shows `{page, offset}` from the next cycle.
- R2: Each byte accepted in an open, unrefused session is acknowledged with `ack_valid_o`=1 and `ack_o`=1 one cycle after the handshake. The offset then advances by one and wraps from 63 to 0 without changing the page.
- R3: When more than 64 bytes are loaded in one session, a later byte replaces the earlier byte at the same offset, and only the latest value is programmed.
- R4: A commit drives `arr_we_o` only for slots loaded in the latest session. It visits them in ascending offset order, one per cycle, at address `{page, offset}`, and every write falls inside the write cycle.
- R5: A STOP that ends a session holding at least one accepted byte raises `busy_o` on the next cycle. `busy_o` then stays high for exactly `WR_CYCLES` cycles.
- R6: While `busy_o` is high, `byte_ready_o` is low, and any load-address, STOP, sample or data strobe has no effect on the address, the buffer or the acknowledgements.
- R7: If the write-protect pin was sampled high before the first data byte, that byte and every later byte of the session get `ack_o`=0. The following STOP starts no write cycle.
- R8: A low write-protect sample, or no sample at all, lets writes proceed. A sample strobe after the first accepted byte of a session is ignored.
- R9: A STOP in a session with no accepted byte, or in a refused session, leaves `busy_o` low and issues no array write.
- R10: After a commit, `cur_addr_o` holds the committed page with the offset that follows the last loaded byte.
- R11: A data byte sent when no session is open is answered with `ack_o`=0 and is not stored.
- R12: After reset, `busy_o`=0, `byte_ready_o`=1, `ack_valid_o`=0, `arr_we_o`=0 and `cur_addr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load_i | input | 1 | Opens a session and loads the address |
| addr_i | input | ADDR_W | Byte address taken with `addr_load_i` |
| wp_sample_i | input | 1 | Strobe that latches the write-protect pin |
| wp_pin_i | input | 1 | Write-protect level, high means protected |
| byte_valid_i | input | 1 | Data byte offered |
| byte_ready_o | output | 1 | Block can take a data byte this cycle |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Ends the session and commits if allowed |
| ack_valid_o | output | 1 | A byte decision is presented |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| busy_o | output | 1 | Write cycle in progress |
| cur_addr_o | output | ADDR_W | Current address counter `{page, offset}` |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
A corrupt offset counter shows at once on `cur_addr_o`. It also puts a wrong address on the array write port during the next commit, within 64 cycles of the STOP. A stale or wrongly cleared valid mask shows as an extra or missing array write in that same 64-cycle walk. The scoreboard flags every extra or missing write individually. A wrong refusal or protect latch shows on the very next `ack_o`. A counter fault in the write-cycle timer shows as a `busy_o` pulse whose length differs from `WR_CYCLES`, which is measured exactly.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // one event is served per cycle, listed from highest priority down
  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_STOP   = 3'd1,
    EV_LOAD   = 3'd2,
    EV_BYTE   = 3'd3,
    EV_SAMPLE = 3'd4
  } pgwr_ev_e;
endpackage

// File: rtl/pgwr_store.sv
module pgwr_store #(
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic              vld_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_ofs_i == OFS_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)     vld_q[g] <= 1'b0;
      else if (clr_i) vld_q[g] <= 1'b0;
      else if (hit)   vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o  = data_q[rd_ofs_i];
  assign rd_valid_o = vld_q[rd_ofs_i];
endmodule

// File: rtl/pgwr_cycle.sv
module pgwr_cycle #(
  parameter int OFS_W     = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             walk_o,
  output logic [OFS_W-1:0] walk_ofs_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int IDX_W = OFS_W + 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
      idx_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
      if (!idx_q[OFS_W]) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o     = busy_q;
  assign walk_o     = busy_q && !idx_q[OFS_W];
  assign walk_ofs_o = idx_q[OFS_W-1:0];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OFS_W     = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_sample_i,
  input  logic              wp_pin_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int PG_W = ADDR_W - OFS_W;

  logic [PG_W-1:0]  page_q;
  logic [OFS_W-1:0] ofs_q;
  logic             sess_q, has_data_q, rej_q, wp_q;
  logic             ack_v_q, ack_q;
  pgwr_ev_e         ev;
  logic             byte_ok, commit_go;
  logic             walk;
  logic [OFS_W-1:0] walk_ofs;
  logic [DATA_W-1:0] slot_data;
  logic             slot_vld;

  assign byte_ready_o = !busy_o && !stop_i && !addr_load_i;

  always_comb begin
    ev = EV_NONE;
    if (!busy_o) begin
      if (stop_i)                            ev = EV_STOP;
      else if (addr_load_i)                  ev = EV_LOAD;
      else if (byte_valid_i && byte_ready_o) ev = EV_BYTE;
      else if (wp_sample_i)                  ev = EV_SAMPLE;
    end
  end

  // the protect latch only matters for the first byte of a session
  assign byte_ok   = sess_q && !rej_q && (has_data_q || !wp_q);
  assign commit_go = (ev == EV_STOP) && sess_q && has_data_q && !rej_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q     <= '0;
      ofs_q      <= '0;
      sess_q     <= 1'b0;
      has_data_q <= 1'b0;
      rej_q      <= 1'b0;
      wp_q       <= 1'b0;
      ack_v_q    <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      ack_v_q <= (ev == EV_BYTE);
      ack_q   <= (ev == EV_BYTE) && byte_ok;
      case (ev)
        EV_STOP: begin
          sess_q     <= 1'b0;
          has_data_q <= 1'b0;
          rej_q      <= 1'b0;
          wp_q       <= 1'b0;
        end
        EV_LOAD: begin
          sess_q     <= 1'b1;
          page_q     <= addr_i[ADDR_W-1:OFS_W];
          ofs_q      <= addr_i[OFS_W-1:0];
          has_data_q <= 1'b0;
          rej_q      <= 1'b0;
          wp_q       <= 1'b0;
        end
        EV_BYTE: begin
          if (byte_ok) begin
            ofs_q      <= ofs_q + OFS_W'(1);
            has_data_q <= 1'b1;
          end else if (sess_q && !has_data_q) begin
            rej_q <= 1'b1;
          end
        end
        EV_SAMPLE: begin
          if (sess_q && !has_data_q && !rej_q) wp_q <= wp_pin_i;
        end
        default: ;
      endcase
    end
  end

  pgwr_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ev == EV_LOAD),
    .wr_en_i   ((ev == EV_BYTE) && byte_ok),
    .wr_ofs_i  (ofs_q),
    .wr_data_i (byte_data_i),
    .rd_ofs_i  (walk_ofs),
    .rd_data_o (slot_data),
    .rd_valid_o(slot_vld)
  );

  pgwr_cycle #(.OFS_W(OFS_W), .WR_CYCLES(WR_CYCLES)) cycle_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (commit_go),
    .busy_o    (busy_o),
    .walk_o    (walk),
    .walk_ofs_o(walk_ofs)
  );

  assign ack_valid_o = ack_v_q;
  assign ack_o       = ack_q;
  assign cur_addr_o  = {page_q, ofs_q};
  assign arr_we_o    = walk && slot_vld;
  assign arr_addr_o  = {page_q, walk_ofs};
  assign arr_data_o  = slot_data;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int ADDR_W = 14,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid_i,
  input logic              byte_ready_o,
  input logic              stop_i,
  input logic              ack_valid_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  AST_WE_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R4

  AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (arr_addr_o[ADDR_W-1:OFS_W] == cur_addr_o[ADDR_W-1:OFS_W])); // R4

  AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o > $past(arr_addr_o))); // R4

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(byte_valid_i && byte_ready_o)); // R2

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i)); // R5

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $stable(cur_addr_o)); // R6
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid_i(byte_valid_i),
  .byte_ready_o(byte_ready_o),
  .stop_i      (stop_i),
  .ack_valid_o (ack_valid_o),
  .busy_o      (busy_o),
  .cur_addr_o  (cur_addr_o),
  .arr_we_o    (arr_we_o),
  .arr_addr_o  (arr_addr_o)
);

// File: tb/pgwr_ctrl_tb_top.sv
module pgwr_ctrl_tb_top;
  localparam int AW  = 14;
  localparam int OW  = 6;
  localparam int DW  = 8;
  localparam int WRC = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          addr_load_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wp_sample_i = 1'b0;
  logic          wp_pin_i = 1'b0;
  logic          byte_valid_i = 1'b0;
  logic          byte_ready_o;
  logic [DW-1:0] byte_data_i = '0;
  logic          stop_i = 1'b0;
  logic          ack_valid_o, ack_o, busy_o, arr_we_o;
  logic [AW-1:0] cur_addr_o, arr_addr_o;
  logic [DW-1:0] arr_data_o;

  pgwr_ctrl #(.ADDR_W(AW), .OFS_W(OW), .DATA_W(DW), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .wp_sample_i(wp_sample_i), .wp_pin_i(wp_pin_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o), .byte_data_i(byte_data_i),
    .stop_i(stop_i), .ack_valid_o(ack_valid_o), .ack_o(ack_o), .busy_o(busy_o),
    .cur_addr_o(cur_addr_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o)
  );

  int errors = 0;
  int checks = 0;
  logic [AW+DW-1:0] exp_q [$];
  logic [AW+DW-1:0] mon_e;
  logic [DW-1:0] mb [64];
  bit            mv [64];
  int            mpage, mofs;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: each array write must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && arr_we_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected array write", int'({arr_addr_o, arr_data_o}), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({arr_addr_o, arr_data_o} == mon_e, "R4", "array write addr/data",
            int'({arr_addr_o, arr_data_o}), int'(mon_e));
      end
    end
  end

  task automatic load(input int addr);
    @(negedge clk);
    addr_load_i = 1'b1;
    addr_i      = AW'(addr);
    @(negedge clk);
    addr_load_i = 1'b0;
    mpage = (addr >> 6) & 8'hFF;
    mofs  = addr & 63;
    for (int i = 0; i < 64; i++) mv[i] = 1'b0;
  endtask

  task automatic sample(input bit wp);
    @(negedge clk);
    wp_pin_i    = wp;
    wp_sample_i = 1'b1;
    @(negedge clk);
    wp_sample_i = 1'b0;
    wp_pin_i    = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit exp, input string req);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_data_i  = d;
    chk(byte_ready_o == 1'b1, req, "ready before byte", int'(byte_ready_o), 1);
    @(negedge clk);
    byte_valid_i = 1'b0;
    chk(ack_valid_o == 1'b1 && ack_o == exp, req, "ack decision",
        int'({ack_valid_o, ack_o}), int'({1'b1, exp}));
    if (exp) begin
      mb[mofs] = d;
      mv[mofs] = 1'b1;
      mofs = (mofs + 1) % 64;
    end
  endtask

  // driver: pushes the expected writes, then issues STOP and times busy
  task automatic stop(input bit commit, input bit poke, input string req);
    int n;
    if (commit)
      for (int o = 0; o < 64; o++)
        if (mv[o]) exp_q.push_back({AW'((mpage << 6) | o), mb[o]});
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    if (commit) begin
      n = 0;
      while (busy_o) begin
        n++;
        if (poke && n == 2) begin
          chk(byte_ready_o == 1'b0, "R6", "ready during write cycle", int'(byte_ready_o), 0);
          addr_load_i = 1'b1; addr_i = '1; byte_valid_i = 1'b1; byte_data_i = 8'hEE;
          stop_i = 1'b1; wp_sample_i = 1'b1; wp_pin_i = 1'b1;
        end else if (poke && n == 3) begin
          addr_load_i = 1'b0; byte_valid_i = 1'b0; stop_i = 1'b0;
          wp_sample_i = 1'b0; wp_pin_i = 1'b0;
          chk(ack_valid_o == 1'b0, "R6", "ack during write cycle", int'(ack_valid_o), 0);
        end
        @(negedge clk);
      end
      chk(n == WRC, req, "busy length", n, WRC);
      chk(exp_q.size() == 0, "R4", "writes left pending", exp_q.size(), 0);
    end else begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, req, "no write cycle", int'(busy_o), 0);
      chk(exp_q.size() == 0, req, "no writes expected", exp_q.size(), 0);
    end
    for (int i = 0; i < 64; i++) mv[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy_o == 1'b0 && byte_ready_o == 1'b1 && ack_valid_o == 1'b0 && arr_we_o == 1'b0,
        "R12", "reset outputs", int'({busy_o, byte_ready_o, ack_valid_o, arr_we_o}), 4'b0100);
    chk(cur_addr_o == '0, "R12", "reset address", int'(cur_addr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // basic session, no protect sample (R8), then poke during busy (R6)
    load(14'h0123);
    chk(cur_addr_o == 14'h0123, "R1", "loaded address", int'(cur_addr_o), 14'h0123);
    send(8'hAA, 1'b1, "R2");
    send(8'hBB, 1'b1, "R8");
    send(8'hCC, 1'b1, "R2");
    chk(cur_addr_o == 14'h0126, "R2", "offset advance", int'(cur_addr_o), 14'h0126);
    stop(1'b1, 1'b1, "R5");
    chk(cur_addr_o == 14'h0126, "R10", "address after commit", int'(cur_addr_o), 14'h0126);

    // wrap and overwrite: 70 bytes from offset 61 of page A9h
    load(14'h2A7D);
    for (int i = 0; i < 70; i++) send(8'(8'h40 + i), 1'b1, "R3");
    chk(cur_addr_o == 14'h2A43, "R2", "offset wrap within page", int'(cur_addr_o), 14'h2A43);
    stop(1'b1, 1'b0, "R5");
    chk(cur_addr_o == 14'h2A43, "R10", "address after wrapped commit", int'(cur_addr_o), 14'h2A43);

    // protected session is refused
    load(14'h0040);
    sample(1'b1);
    send(8'h11, 1'b0, "R7");
    send(8'h22, 1'b0, "R7");
    stop(1'b0, 1'b0, "R7");

    // late protect sample ignored
    load(14'h0050);
    sample(1'b0);
    send(8'h33, 1'b1, "R8");
    sample(1'b1);
    send(8'h44, 1'b1, "R8");
    stop(1'b1, 1'b0, "R8");

    // STOP with empty session
    load(14'h1000);
    stop(1'b0, 1'b0, "R9");

    // byte outside any session
    send(8'h55, 1'b0, "R11");
    stop(1'b0, 1'b0, "R11");

    // single sparse byte: only that slot is written
    load(14'h0008);
    send(8'h77, 1'b1, "R4");
    stop(1'b1, 1'b0, "R4");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule